// File: doc/BRIEF.md
# Host-Settable Millisecond Timestamp

The block keeps a controller timestamp that the host can set and query. A host write loads a 64-bit word. From that point the block adds one to a 48-bit running count on every millisecond tick pulse. The tick comes from a divider outside the block. A host read returns a packed 64-bit word with these parts:

- the running time;
- a zero sync flag;
- an origin code, which tells whether the host ever set a non-zero time;
- zeroed reserved bits.

A single write strobe and a read port stand in for the command path and the data mover that would surround the block in a controller. Enabling the controller has the same effect as a host write of zero: the count restarts from zero and the origin code returns to "not set". Reads are registered, so results appear one cycle after the request.

Top module: `host_timestamp`

## Requirements
- R1: The read word places the running time in bits 47:0, the sync flag in bit 48, the origin code in bits 51:49 and reserved bits in 63:52.
- R2: The running time equals the low 48 bits of the last host write plus the number of ms_tick pulses accepted since that write, taken modulo 2^48. The value 2^48-1 plus one tick reads as 0.
- R3: The origin code reads 1 when the whole 64-bit value last written by the host is non-zero, and 0 when that value is zero. A value whose only set bits lie above bit 47 seeds a time of 0 and an origin of 1.
- R4: The sync flag and the reserved bits always read as zero, even after a write that sets those bit positions.
- R5: A ctrl_en pulse clears the running time and the origin code to zero. When ctrl_en and wr_en are high in the same cycle, ctrl_en wins.
- R6: An ms_tick in the same cycle as a host write is ignored, so the first read after the write returns exactly the written low 48 bits.
- R7: A read accepted at a clock edge gives rd_valid high and rd_data after that edge. The data reflects the state before any write, tick or enable in the same cycle.
- R8: Synchronous active-high reset clears rd_valid, rd_data, the running time and the origin code.
- R9: Byte k of the payload occupies bits 8k+7:8k of both wr_data and rd_data (little-endian byte order). Byte 0 is the least significant byte of the time.
- R10: rd_data holds its last value while rd_en is low, even as ticks advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller-enable pulse; reseeds the time with zero |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 64 | Host timestamp payload, little-endian bytes |
| rd_en | input | 1 | Host read request |
| rd_data | output | 64 | Packed timestamp word |
| rd_valid | output | 1 | rd_data was loaded by the read one cycle earlier |

## Verification
The bench builds the block with its default 48-bit time field and the full 64-bit payload. The wrap case is reached by seeding the count two below 2^48 and ticking past the top, so no long run is needed. The full payload width lets writes with only reserved or upper bits set show that the origin decision uses all 64 bits, while the count and the read word ignore those bits.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int WORD_W   = 64;
  localparam int TIME_W   = 48;
  localparam int ORIGIN_W = 3;
  localparam int RSVD_W   = WORD_W - TIME_W - 1 - ORIGIN_W;

  localparam logic [ORIGIN_W-1:0] ORIGIN_UNSET = '0;
  localparam logic [ORIGIN_W-1:0] ORIGIN_HOST  = ORIGIN_W'(1);

  // Packed read word; the first member lands in the most significant bits.
  typedef struct packed {
    logic [RSVD_W-1:0]   rsvd;
    logic [ORIGIN_W-1:0] origin;
    logic                sync;
    logic [TIME_W-1:0]   stamp;
  } ts_word_t;
endpackage

// File: rtl/hts_ms_counter.sv
module hts_ms_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  // Clear beats load, and load beats tick, so a tick during a load is lost.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/hts_origin_track.sv
module hts_origin_track #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          host_set
);
  // The decision looks at every written bit, not only the time field.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      host_set <= 1'b0;
    end else if (load) begin
      host_set <= |load_val;
    end
  end
endmodule

// File: rtl/hts_readout.sv
module hts_readout
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [TIME_W-1:0] stamp,
  input  logic              host_set,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  ts_word_t word_d;

  always_comb begin
    word_d        = '0;
    word_d.stamp  = stamp;
    word_d.sync   = 1'b0;
    word_d.origin = host_set ? ORIGIN_HOST : ORIGIN_UNSET;
    word_d.rsvd   = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= word_d;
      end
    end
  end
endmodule

// File: rtl/host_timestamp.sv
module host_timestamp
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [TIME_W-1:0] stamp_q;
  logic              host_set_q;

  hts_ms_counter #(.W(TIME_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clear    (ctrl_en),
    .load     (wr_en),
    .load_val (wr_data[TIME_W-1:0]),
    .tick     (ms_tick),
    .count    (stamp_q)
  );

  hts_origin_track #(.DW(WORD_W)) u_origin (
    .clk      (clk),
    .rst      (rst),
    .clear    (ctrl_en),
    .load     (wr_en),
    .load_val (wr_data),
    .host_set (host_set_q)
  );

  hts_readout u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .stamp    (stamp_q),
    .host_set (host_set_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/hts_checker.sv
module hts_checker
  import hts_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ctrl_en,
  input logic              ms_tick,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [TIME_W-1:0] count,
  input logic              host_set
);
  p_tick_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !wr_en && ms_tick) |=> (count == TIME_W'($past(count) + 1)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !wr_en && !ms_tick) |=> $stable(count) && $stable(host_set));

  p_write_seed_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && wr_en) |=> (count == $past(wr_data[TIME_W-1:0])));

  p_origin_any_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && wr_en) |=> (host_set == ($past(wr_data) != '0)));

  p_enable_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_en |=> (count == '0) && !host_set);

  p_zero_fields_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[WORD_W-1:TIME_W+1+ORIGIN_W] == '0) && !rd_data[TIME_W]);

  p_origin_code_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[TIME_W+ORIGIN_W:TIME_W+1] <= ORIGIN_HOST));

  p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_read_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind host_timestamp hts_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_en  (ctrl_en),
  .ms_tick  (ms_tick),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .count    (stamp_q),
  .host_set (host_set_q)
);

// File: tb/host_timestamp_bench.sv
`timescale 1ns/1ps
module host_timestamp_bench;
  logic        clk = 1'b0;
  logic        rst, ctrl_en, ms_tick, wr_en, rd_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  // Reference state, updated from the requirements only.
  logic [47:0] m_ts;
  logic        m_org;
  logic [63:0] last_pushed;

  always #2.5 clk = ~clk;

  host_timestamp u_host_timestamp (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ms_tick(ms_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [63:0] pack(input logic [47:0] t, input logic o);
    // R1 layout: time 47:0, sync 48, origin 51:49, reserved 63:52
    return {12'h000, (o ? 3'd1 : 3'd0), 1'b0, t};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushing the expected read result.
  task automatic step(input logic en, input logic wr, input logic [63:0] wd,
                      input logic tk, input logic rd, input string tag);
    @(negedge clk);
    ctrl_en = en; wr_en = wr; wr_data = wd; ms_tick = tk; rd_en = rd;
    if (rd) begin
      last_pushed = pack(m_ts, m_org);
      exp_q.push_back(last_pushed);
      tag_q.push_back(tag);
    end
    if (en) begin
      m_ts = '0; m_org = 1'b0;
    end else if (wr) begin
      m_ts = wd[47:0]; m_org = (wd != 64'd0);
    end else if (tk) begin
      m_ts = m_ts + 48'd1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 64'd0, 1, 0, "");
  endtask

  // Monitor: compare each produced read with the queue head.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected rd_valid", rd_data, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(0, "watchdog", 64'd0, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; ctrl_en = 0; ms_tick = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    m_ts = '0; m_org = 0; last_pushed = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(rd_valid == 1'b0, "R8 reset rd_valid", {63'd0, rd_valid}, 64'd0);
    check(rd_data == 64'd0, "R8 reset rd_data", rd_data, 64'd0);
    step(0, 0, 64'd0, 0, 1, "R8 read after reset");
    ticks(5);
    step(0, 0, 64'd0, 0, 1, "R2 count from zero");
    // R7: read in the write cycle returns the old value
    step(0, 1, 64'h0000_1234_5678_9abc, 0, 1, "R7 read beside write");
    step(0, 0, 64'd0, 0, 1, "R3 origin after nonzero write");
    // R6: tick during write dropped
    step(0, 1, 64'h0000_0000_0000_0100, 1, 0, "");
    step(0, 0, 64'd0, 0, 1, "R6 tick with write ignored");
    ticks(3);
    step(0, 0, 64'd0, 0, 1, "R2 ticks after write");
    // R2 wrap
    step(0, 1, 64'h0000_ffff_ffff_fffe, 0, 0, "");
    ticks(3);
    step(0, 0, 64'd0, 0, 1, "R2 wrap modulo 2^48");
    // R3/R4: only upper bits set
    step(0, 1, 64'habc0_0000_0000_0000, 0, 0, "");
    step(0, 0, 64'd0, 0, 1, "R3 R4 upper-only write");
    step(0, 1, 64'hfff1_0000_0000_0005, 0, 0, "");
    step(0, 0, 64'd0, 0, 1, "R4 sync and reserved read zero");
    step(0, 1, 64'd0, 0, 0, "");
    step(0, 0, 64'd0, 0, 1, "R3 zero write origin");
    // R9 byte order
    step(0, 1, 64'h0000_0605_0403_0201, 0, 0, "");
    step(0, 0, 64'd0, 0, 1, "R9 byte order");
    @(negedge clk); rd_en = 0; #1;
    check(rd_data[7:0] == 8'h01 && rd_data[15:8] == 8'h02,
          "R9 byte 0 and 1 lanes", rd_data, 64'h0000_0000_0000_0201 | rd_data);
    // R10 hold while ticking
    ticks(4);
    #1;
    check(rd_data == last_pushed, "R10 hold without read", rd_data, last_pushed);
    // R5 enable beats write
    ticks(2);
    step(1, 1, 64'h0000_0000_0000_7777, 0, 0, "");
    step(0, 0, 64'd0, 0, 1, "R5 enable wins over write");
    ticks(2);
    step(0, 0, 64'd0, 0, 1, "R5 count restarts after enable");
    step(0, 0, 64'd0, 0, 0, "");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads returned", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule